// File: doc/BRIEF.md
# Return-Material Wipe Sequencer with Flash Arbitration

The block stands between a flash protocol engine and two requesters: a software command port and a hardware return-material (RMA) request from the lifecycle logic. While no RMA is pending, software commands pass straight through to the engine. The engine's completion, error and read data flow back to software.

An RMA request is latched on arrival. If a software operation is in flight, that operation runs to completion first. At the next operation boundary the block takes the engine for good and raises the software-blocked flag. A sequencer then walks a configured page range in ascending order. On each page it erases, programs a fixed wipe pattern, and reads the page back to compare it with the pattern. A clean pass ends in a terminal state with a one-cycle acknowledge. An engine error, or a read-back mismatch, sends the sequencer to a terminal invalid state and raises a sticky fatal flag. Both terminal states last until reset.

Top module: `rma_wipe_arb`

## Requirements
- R1: An RMA request that arrives while a software operation is outstanding leaves that operation untouched until it completes. The operation is outstanding from its forwarding until `eng_done_i`. `sw_blocked_o` stays 0 until then.
- R2: A one-cycle pulse on `rma_req_i` is enough to start the wipe. When no software operation is outstanding, the RMA wins over a software request presented in the same cycle, and that software request never reaches the engine.
- R3: From the cycle the RMA is granted until reset:
  - `sw_blocked_o` is 1.
  - No software request reaches the engine.
  - `sw_done_o` stays 0.
- R4: The wipe visits pages START_PAGE to END_PAGE in ascending order. On each page it issues three engine operations in this order:
  - erase (op 2'b10);
  - program (op 2'b01), with `eng_wdata_o` equal to WIPE_PAT;
  - read (op 2'b00).

  `eng_req_o` is held with stable op and address until `eng_done_i`.
- R5: After a successful wipe, every page in the range holds WIPE_PAT, and pages outside the range are unchanged.
- R6: On successful completion, `rma_ack_o` pulses high for exactly one cycle. The block then stays in its final state with no further engine requests, `sw_blocked_o` at 1 and `fatal_err_o` at 0.
- R7: `eng_err_i` at the completion of a wipe operation (in particular a program) puts the sequencer in the invalid state. In that state `fatal_err_o` is set and sticky, `rma_ack_o` never pulses, and no further engine request is made.
- R8: A read-back value that differs from WIPE_PAT during verify also leads to the invalid state, with the same outputs as R7.
- R9: With no RMA pending, a software request is forwarded with its op, address and data. The engine's done, error and read data are returned to the software port.
- R10: After reset, `eng_req_o`, `rma_ack_o`, `sw_blocked_o` and `fatal_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_req_i | input | 1 | Software request, held until `sw_done_o` |
| sw_op_i | input | 2 | Software operation: 00 read, 01 program, 10 erase |
| sw_addr_i | input | PAGE_W | Software page address |
| sw_wdata_i | input | DATA_W | Software program data |
| sw_done_o | output | 1 | Software operation complete |
| sw_err_o | output | 1 | Software operation error, valid with `sw_done_o` |
| sw_rdata_o | output | DATA_W | Read data returned to software |
| rma_req_i | input | 1 | RMA request (pulse or level) |
| rma_ack_o | output | 1 | One-cycle pulse on successful wipe |
| sw_blocked_o | output | 1 | Software locked out, sticky until reset |
| fatal_err_o | output | 1 | Wipe failed, sticky until reset |
| eng_req_o | output | 1 | Engine request, held until `eng_done_i` |
| eng_op_o | output | 2 | Engine operation |
| eng_addr_o | output | PAGE_W | Engine page address |
| eng_wdata_o | output | DATA_W | Engine program data |
| eng_done_i | input | 1 | Engine operation complete (one cycle) |
| eng_err_i | input | 1 | Engine error, valid with `eng_done_i` |
| eng_rdata_i | input | DATA_W | Engine read data, valid with `eng_done_i` |

## Verification
The hardest situations to reach are the two boundary races. In the first, the RMA arrives in the middle of a long software operation. In the second, it arrives in the very cycle a fresh software request appears. The bench covers the first by stretching the engine model's latency and pulsing the RMA request a few cycles into a software program. It covers the second by driving both requests on the same edge from an idle block. In both cases a scoreboard of expected engine operations shows whether the software operation was completed, or dropped, before the first erase. Failure paths are reached by letting the engine model inject an error on one chosen page's program, or corrupt one page's read-back.

// File: rtl/rma_wipe_pkg.sv
package rma_wipe_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE_SEL,
    ST_ERASE,
    ST_PROG,
    ST_VERIFY,
    ST_DONE,
    ST_INVALID
  } wipe_state_e;

endpackage

// File: rtl/rma_wipe_grant.sv
module rma_wipe_grant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  input  logic rma_req_i,
  input  logic eng_done_i,
  output logic sw_fwd_o,
  output logic sw_busy_o,
  output logic granted_o
);
  logic pend_q, busy_q, granted_q;
  logic pend, hold;

  assign pend = pend_q | rma_req_i;
  // hold new software work once an RMA waits and nothing is in flight
  assign hold = pend & ~busy_q;
  assign sw_fwd_o  = sw_req_i & ~hold;
  assign sw_busy_o = busy_q;
  assign granted_o = granted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      busy_q    <= 1'b0;
      granted_q <= 1'b0;
    end else begin
      pend_q    <= pend;
      busy_q    <= (busy_q | sw_fwd_o) & ~eng_done_i;
      granted_q <= granted_q | hold;
    end
  end
endmodule

// File: rtl/rma_wipe_seq.sv
module rma_wipe_seq
  import rma_wipe_pkg::*;
#(
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned START_PAGE = 8,
  parameter int unsigned END_PAGE   = 11,
  parameter logic [DATA_W-1:0] WIPE_PAT = 32'hA5C3_5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              req_o,
  output flash_op_e         op_o,
  output logic [PAGE_W-1:0] addr_o,
  output logic              ack_o,
  output logic              fatal_o
);
  localparam logic [PAGE_W-1:0] FIRST = PAGE_W'(START_PAGE);
  localparam logic [PAGE_W-1:0] LAST  = PAGE_W'(END_PAGE);

  wipe_state_e state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    ack_d   = 1'b0;
    req_o   = 1'b0;
    op_o    = OP_READ;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PAGE_SEL;
        page_d  = FIRST;
      end
      ST_PAGE_SEL: state_d = ST_ERASE;
      ST_ERASE: begin
        req_o = 1'b1;
        op_o  = OP_ERASE;
        if (eng_done_i) state_d = eng_err_i ? ST_INVALID : ST_PROG;
      end
      ST_PROG: begin
        req_o = 1'b1;
        op_o  = OP_PROG;
        if (eng_done_i) state_d = eng_err_i ? ST_INVALID : ST_VERIFY;
      end
      ST_VERIFY: begin
        req_o = 1'b1;
        op_o  = OP_READ;
        if (eng_done_i) begin
          if (eng_err_i || (eng_rdata_i != WIPE_PAT)) begin
            state_d = ST_INVALID;
          end else if (page_q == LAST) begin
            state_d = ST_DONE;
            ack_d   = 1'b1;
          end else begin
            page_d  = page_q + PAGE_W'(1);
            state_d = ST_PAGE_SEL;
          end
        end
      end
      ST_DONE, ST_INVALID: state_d = state_q;
      default: state_d = ST_INVALID;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      ack_q   <= ack_d;
    end
  end

  assign addr_o  = page_q;
  assign ack_o   = ack_q;
  assign fatal_o = (state_q == ST_INVALID);
endmodule

// File: rtl/rma_wipe_arb.sv
module rma_wipe_arb
  import rma_wipe_pkg::*;
#(
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned START_PAGE = 8,
  parameter int unsigned END_PAGE   = 11,
  parameter logic [DATA_W-1:0] WIPE_PAT = 32'hA5C3_5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_req_i,
  input  logic [1:0]        sw_op_i,
  input  logic [PAGE_W-1:0] sw_addr_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  output logic              sw_done_o,
  output logic              sw_err_o,
  output logic [DATA_W-1:0] sw_rdata_o,
  input  logic              rma_req_i,
  output logic              rma_ack_o,
  output logic              sw_blocked_o,
  output logic              fatal_err_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [PAGE_W-1:0] eng_addr_o,
  output logic [DATA_W-1:0] eng_wdata_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic [DATA_W-1:0] eng_rdata_i
);
  logic sw_fwd, sw_busy, granted;
  logic seq_req;
  flash_op_e seq_op;
  logic [PAGE_W-1:0] seq_addr;

  rma_wipe_grant u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_req_i   (sw_req_i),
    .rma_req_i  (rma_req_i),
    .eng_done_i (eng_done_i),
    .sw_fwd_o   (sw_fwd),
    .sw_busy_o  (sw_busy),
    .granted_o  (granted)
  );

  rma_wipe_seq #(
    .PAGE_W     (PAGE_W),
    .DATA_W     (DATA_W),
    .START_PAGE (START_PAGE),
    .END_PAGE   (END_PAGE),
    .WIPE_PAT   (WIPE_PAT)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (granted),
    .eng_done_i  (eng_done_i),
    .eng_err_i   (eng_err_i),
    .eng_rdata_i (eng_rdata_i),
    .req_o       (seq_req),
    .op_o        (seq_op),
    .addr_o      (seq_addr),
    .ack_o       (rma_ack_o),
    .fatal_o     (fatal_err_o)
  );

  always_comb begin
    if (granted) begin
      eng_req_o   = seq_req;
      eng_op_o    = seq_op;
      eng_addr_o  = seq_addr;
      eng_wdata_o = WIPE_PAT;
    end else begin
      eng_req_o   = sw_fwd;
      eng_op_o    = sw_op_i;
      eng_addr_o  = sw_addr_i;
      eng_wdata_o = sw_wdata_i;
    end
  end

  assign sw_blocked_o = granted;
  assign sw_done_o    = eng_done_i & sw_busy;
  assign sw_err_o     = eng_err_i & sw_busy;
  assign sw_rdata_o   = eng_rdata_i;
endmodule

// File: rtl/rma_wipe_chk.sv
module rma_wipe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_busy,
  input logic sw_blocked_o,
  input logic sw_done_o,
  input logic rma_ack_o,
  input logic fatal_err_o,
  input logic eng_req_o
);
  assert_grant_boundary_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_blocked_o) |-> $past(!sw_busy));

  assert_blocked_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_blocked_o |=> sw_blocked_o);

  assert_no_sw_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_blocked_o |-> !sw_done_o);

  assert_ack_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rma_ack_o |=> !rma_ack_o);

  assert_ack_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rma_ack_o |-> (sw_blocked_o && !fatal_err_o));

  assert_fatal_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_err_o |=> fatal_err_o);

  assert_fatal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_err_o |-> (!eng_req_o && !rma_ack_o));
endmodule

bind rma_wipe_arb rma_wipe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_busy      (sw_busy),
  .sw_blocked_o (sw_blocked_o),
  .sw_done_o    (sw_done_o),
  .rma_ack_o    (rma_ack_o),
  .fatal_err_o  (fatal_err_o),
  .eng_req_o    (eng_req_o)
);

// File: tb/sim_rma_wipe_arb.sv
`timescale 1ns/1ps
module sim_rma_wipe_arb;
  localparam int PW = 6;
  localparam int DW = 32;
  localparam int FIRST = 8;
  localparam int LAST = 11;
  localparam logic [DW-1:0] PAT = 32'hA5C3_5A3C;
  localparam logic [1:0] RD = 2'b00, PG = 2'b01, ER = 2'b10;

  logic clk_i = 0, rst_ni = 0;
  logic sw_req_i = 0;
  logic [1:0] sw_op_i = 0;
  logic [PW-1:0] sw_addr_i = 0;
  logic [DW-1:0] sw_wdata_i = 0;
  logic sw_done_o, sw_err_o, rma_ack_o, sw_blocked_o, fatal_err_o;
  logic [DW-1:0] sw_rdata_o;
  logic rma_req_i = 0;
  logic eng_req_o;
  logic [1:0] eng_op_o;
  logic [PW-1:0] eng_addr_o;
  logic [DW-1:0] eng_wdata_o;
  logic eng_done_i = 0, eng_err_i = 0;
  logic [DW-1:0] eng_rdata_i = 0;

  always #2 clk_i = ~clk_i;

  rma_wipe_arb #(.PAGE_W(PW), .DATA_W(DW), .START_PAGE(FIRST), .END_PAGE(LAST),
                 .WIPE_PAT(PAT)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] mem [64];
  logic [39:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // engine model and scoreboard monitor
  int lat = 2;
  bit e_busy = 0;
  int e_cnt = 0;
  logic [1:0] e_op;
  logic [PW-1:0] e_addr;
  logic [DW-1:0] e_wdata;
  bit inj_err = 0, inj_bad = 0;
  int inj_page = 0;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      e_busy = 0; eng_done_i = 0; eng_err_i = 0;
    end else begin
      if (e_busy && eng_done_i) begin
        eng_done_i = 0; eng_err_i = 0; e_busy = 0;
      end else if (e_busy) begin
        e_cnt--;
        if (e_cnt == 0) begin
          eng_done_i = 1;
          if (inj_err && e_op == PG && int'(e_addr) == inj_page) eng_err_i = 1;
          else if (e_op == ER) mem[e_addr] = '1;
          else if (e_op == PG) mem[e_addr] = mem[e_addr] & e_wdata;
          eng_rdata_i = mem[e_addr];
          if (inj_bad && e_op == RD && int'(e_addr) == inj_page) eng_rdata_i = ~mem[e_addr];
        end
      end
      if (!e_busy && eng_req_o) begin
        e_busy = 1; e_cnt = lat;
        e_op = eng_op_o; e_addr = eng_addr_o; e_wdata = eng_wdata_o;
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected engine op", {e_op, e_addr}, 0);
        end else begin
          logic [39:0] x;
          x = exp_q.pop_front();
          chk({e_op, e_addr} == x[39:32], "R4 op/addr order", {e_op, e_addr}, x[39:32]);
          if (x[39:38] == PG) chk(e_wdata == x[31:0], "R4 program data", e_wdata, x[31:0]);
        end
      end
    end
  end

  // held request must keep op/address stable until done
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && e_busy && !eng_done_i && eng_req_o)
      if (eng_op_o != e_op || eng_addr_o != e_addr)
        chk(0, "R4 held op stable", {eng_op_o, eng_addr_o}, {e_op, e_addr});
  end

  int ack_cnt = 0;
  always begin
    @(negedge clk_i); #1;
    if (rma_ack_o) ack_cnt++;
  end

  task automatic push(input logic [1:0] op, input int addr, input logic [DW-1:0] d);
    exp_q.push_back({op, PW'(addr), d});
  endtask

  task automatic push_wipe(input int stop_page, input logic [1:0] stop_op);
    for (int p = FIRST; p <= LAST; p++) begin
      push(ER, p, '0);
      if (p == stop_page && stop_op == ER) return;
      push(PG, p, PAT);
      if (p == stop_page && stop_op == PG) return;
      push(RD, p, '0);
      if (p == stop_page && stop_op == RD) return;
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; sw_req_i = 0; rma_req_i = 0;
    inj_err = 0; inj_bad = 0; ack_cnt = 0;
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    ack_cnt = 0;
  endtask

  bit sw_inflight = 0;
  task automatic sw_op(input logic [1:0] op, input int addr, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output bit ok);
    int t;
    @(posedge clk_i); #1;
    sw_req_i = 1; sw_op_i = op; sw_addr_i = PW'(addr); sw_wdata_i = d;
    sw_inflight = 1;
    ok = 0; t = 0;
    while (t < 500) begin
      @(negedge clk_i); #1;
      if (sw_done_o) begin ok = 1; break; end
      t++;
    end
    rd = sw_rdata_o;
    @(posedge clk_i); #1;
    sw_req_i = 0; sw_inflight = 0;
  endtask

  task automatic wait_sig(input int which, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i); #1;
      if (which == 0 && rma_ack_o) return;
      if (which == 1 && fatal_err_o) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    bit ok;
    int bad;
    for (int p = 0; p < 64; p++) mem[p] = 32'h1000_0000 + p;

    // reset state
    do_reset();
    @(negedge clk_i); #1;
    chk(!eng_req_o && !rma_ack_o && !sw_blocked_o && !fatal_err_o, "R10 reset outputs",
        {eng_req_o, rma_ack_o, sw_blocked_o, fatal_err_o}, 0);

    // software pass-through
    lat = 2;
    push(RD, 5, '0);
    sw_op(RD, 5, '0, rd, ok);
    chk(ok, "R9 sw read done", ok, 1);
    chk(rd == 32'h1000_0005, "R9 sw read data", rd, 32'h1000_0005);
    push(PG, 6, 32'h0F0F_0F0F);
    sw_op(PG, 6, 32'h0F0F_0F0F, rd, ok);
    chk(ok, "R9 sw program done", ok, 1);
    push(RD, 6, '0);
    sw_op(RD, 6, '0, rd, ok);
    chk(rd == (32'h1000_0006 & 32'h0F0F_0F0F), "R9 sw read after program", rd,
        32'h1000_0006 & 32'h0F0F_0F0F);

    // RMA arrives during a long software program
    lat = 6;
    push(PG, 20, 32'h1234_5678);
    push_wipe(-1, RD);
    bad = 0;
    fork
      begin
        logic [DW-1:0] r2; bit o2;
        sw_op(PG, 20, 32'h1234_5678, r2, o2);
      end
      begin
        repeat (2) @(posedge clk_i); #1;
        rma_req_i = 1;
        @(posedge clk_i); #1;
        rma_req_i = 0;
        while (sw_inflight) begin
          @(negedge clk_i); #1;
          if (sw_inflight && sw_blocked_o) bad++;
        end
      end
    join
    chk(bad == 0, "R1 blocked during sw op", bad, 0);
    lat = 3;
    wait_sig(0, 2000);
    repeat (20) @(negedge clk_i); #1;
    chk(ack_cnt == 1, "R6 ack single pulse", ack_cnt, 1);
    chk(!fatal_err_o && sw_blocked_o, "R6 final state", {fatal_err_o, sw_blocked_o}, 1);
    chk(exp_q.size() == 0, "R4 all wipe ops seen", exp_q.size(), 0);
    for (int p = FIRST; p <= LAST; p++)
      chk(mem[p] == PAT, "R5 page wiped", mem[p], PAT);
    chk(mem[20] == (32'h1000_0014 & 32'h1234_5678), "R1 sw op completed", mem[20],
        32'h1000_0014 & 32'h1234_5678);
    chk(mem[7] == 32'h1000_0007, "R5 page below range kept", mem[7], 32'h1000_0007);
    chk(mem[12] == 32'h1000_000C, "R5 page above range kept", mem[12], 32'h1000_000C);

    // software locked out after wipe
    @(posedge clk_i); #1;
    sw_req_i = 1; sw_op_i = ER; sw_addr_i = 3;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i); #1;
      if (eng_req_o || sw_done_o || !sw_blocked_o) bad++;
    end
    sw_req_i = 0;
    chk(bad == 0, "R3 sw blocked after wipe", bad, 0);
    chk(mem[3] == 32'h1000_0003, "R3 blocked erase had no effect", mem[3], 32'h1000_0003);

    // same-cycle race from idle, with a program error on the second page
    do_reset();
    @(negedge clk_i); #1;
    chk(!sw_blocked_o, "R10 blocked cleared by reset", sw_blocked_o, 0);
    lat = 2; inj_err = 1; inj_page = FIRST + 1;
    push_wipe(FIRST + 1, PG);
    @(posedge clk_i); #1;
    sw_req_i = 1; sw_op_i = ER; sw_addr_i = 2; rma_req_i = 1;
    @(posedge clk_i); #1;
    rma_req_i = 0;
    wait_sig(1, 2000);
    bad = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk_i); #1;
      if (eng_req_o || sw_done_o) bad++;
    end
    sw_req_i = 0;
    chk(mem[2] == 32'h1000_0002, "R2 racing sw erase dropped", mem[2], 32'h1000_0002);
    chk(fatal_err_o, "R7 fatal on program error", fatal_err_o, 1);
    chk(ack_cnt == 0, "R7 no ack on failure", ack_cnt, 0);
    chk(bad == 0, "R7 engine quiet after failure", bad, 0);
    chk(sw_blocked_o, "R3 blocked in invalid state", sw_blocked_o, 1);
    chk(exp_q.size() == 0, "R7 ops up to failing program", exp_q.size(), 0);

    // read-back mismatch on the last page
    do_reset();
    lat = 1; inj_bad = 1; inj_page = LAST;
    push_wipe(LAST, RD);
    @(posedge clk_i); #1;
    rma_req_i = 1;
    @(posedge clk_i); #1;
    rma_req_i = 0;
    wait_sig(1, 2000);
    repeat (10) @(negedge clk_i); #1;
    chk(fatal_err_o, "R8 fatal on verify mismatch", fatal_err_o, 1);
    chk(ack_cnt == 0, "R8 no ack on mismatch", ack_cnt, 0);
    chk(exp_q.size() == 0, "R8 all ops issued", exp_q.size(), 0);
    chk(!eng_req_o, "R8 engine idle", eng_req_o, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule